// File: doc/BRIEF.md
# Host Register Port for a Sector Decoder Controller

This block is the host-side register window of a disc sector decoder controller. The host first loads a 5-bit register index with an index strobe. It then issues data reads and data writes against that index. After each data access the index steps forward by one, so the host can sweep a run of registers without reloading it. Most indices select different registers for reads than for writes. This block holds the interface control register, the interface status register and an 8-byte command-input queue that the drive side fills. It drives one interrupt line. Every other register is forwarded: writes appear on a write strobe together with the current index, and reads return a byte supplied from outside.

The status flags are active-low. Reset sets every status bit to 1, which means idle. Some accesses change state as a side effect. Reading index 0 pops the command queue. Reading index 15 withdraws a pending decode interrupt. Writes to indices 0, 1, 6, 7 and 15 each change particular status bits. Two event inputs from the rest of the controller drive the transfer-end and decode flags active.

Top module: `host_reg_port`

## Requirements
- R1: An index-strobe write loads the index from the low 5 bits of `ptr_wdata` and ignores the upper 3 bits. The index is visible on `reg_idx`.
- R2: Every data read, and every data write except a write to index 0, advances the index by one after the access. The index wraps from 31 to 0.
- R3: A data write to index 0 (serial-out) leaves the index unchanged.
- R4: Reading index 0 returns the oldest queued command byte and removes it. Bytes come out in the order they were pushed. Reading index 0 while the queue is empty returns 0xFF.
- R5: Status bit 7 (command pending) goes low when a byte is pushed. It goes high again when a read of index 0 empties the queue.
- R6: A data read of index 15 sets status bit 5 (decode pending) high.
- R7: After reset the status reads 0xFF, the control register reads 0 and the index is 0. A data write to index 15 empties the queue and sets the status back to 0xFF.
- R8: Control (written at index 1) uses these bits: bit 7 command-interrupt enable, bit 6 transfer-end enable, bit 5 decode enable, bit 1 data-output enable, bit 0 serial-output enable. A control write with bit 0 clear sets status bit 2 (status busy). A control write with bit 1 clear sets status bits 3 (data busy) and 6 (transfer end). A write to index 0 while serial-output is enabled clears status bit 2.
- R9: A write to index 6 while data-output is enabled clears status bit 3. A write to index 7 sets status bit 6. A `xfer_done` pulse clears bit 6 and sets bit 3. A `dec_done` pulse clears bit 5.
- R10: `irq` is high exactly when one of status bits 7, 6 or 5 is low and the matching control bit 7, 6 or 5 is set.
- R11: A read at index 1 returns the status. A read at indices 2 to 15 returns `ext_rd_data`. A read at any index from 16 to 31 returns 0xFF.
- R12: A push that arrives while the queue already holds 8 bytes is dropped.
- R13: `ext_wr_en` pulses for data writes to index 0 and to indices 2 to 14. It stays low for writes to indices 1, 15 and 16 to 31.
- R14: An index-strobe write takes priority over a data access in the same cycle. That data access is dropped and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Index strobe |
| ptr_wdata | input | 8 | Index value; low 5 bits kept |
| data_we | input | 1 | Data write at current index |
| data_re | input | 1 | Data read at current index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for current index |
| reg_idx | output | 5 | Current register index |
| ext_wr_en | output | 1 | Forwarded write strobe |
| ext_rd_data | input | 8 | Read data of forwarded registers |
| cmd_push | input | 1 | Drive-side command byte push |
| cmd_byte | input | 8 | Pushed command byte |
| xfer_done | input | 1 | Transfer-finished event pulse |
| dec_done | input | 1 | Decode-finished event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Most faults in this block show up directly at the pins. An index that steps wrongly appears on `reg_idx` in the cycle after the access. A misaligned queue pointer or count appears on the next read of index 0 as a wrong byte, or as a 0xFF too early or too late. A wrong status bit is seen on the next read at index 1 and, when its enable is set, on `irq` immediately. The bench therefore follows each side effect with a status read or an interrupt sample before the next stimulus.

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int DEPTH = 8,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic [7:0]    ptr_wdata,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [PW-1:0] reg_idx,
  output logic          ext_wr_en,
  input  logic [7:0]    ext_rd_data,
  input  logic          cmd_push,
  input  logic [7:0]    cmd_byte,
  input  logic          xfer_done,
  input  logic          dec_done,
  output logic          irq
);
  localparam int FAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int NREG = 16;
  localparam logic [PW-1:0] IX_CMD  = PW'(0);
  localparam logic [PW-1:0] IX_IF   = PW'(1);
  localparam logic [PW-1:0] IX_TRIG = PW'(6);
  localparam logic [PW-1:0] IX_ACK  = PW'(7);
  localparam logic [PW-1:0] IX_RST  = PW'(15);

  logic [PW-1:0]  ptr_q;
  logic [7:0]     ctrl_q, stat_q, stat_d;
  logic [7:0]     mem [DEPTH];
  logic [FAW-1:0] rp_q, wp_q;
  logic [CW-1:0]  cnt_q;

  wire do_wr   = data_we & ~ptr_we;
  wire do_rd   = data_re & ~data_we & ~ptr_we;
  wire in_file = ptr_q < PW'(NREG);
  wire empty   = cnt_q == '0;
  wire full    = cnt_q == CW'(DEPTH);
  wire at_cmd  = ptr_q == IX_CMD;
  wire wr_rst  = do_wr & (ptr_q == IX_RST);
  wire pop     = do_rd & at_cmd & ~empty;
  wire push_ok = cmd_push & ~full & ~wr_rst;

  assign reg_idx   = ptr_q;
  assign ext_wr_en = do_wr & in_file & (ptr_q != IX_IF) & (ptr_q != IX_RST);
  assign irq       = |(ctrl_q[7:5] & ~stat_q[7:5]);

  always_comb begin
    if (!in_file)              rdata = 8'hFF;
    else if (at_cmd)           rdata = empty ? 8'hFF : mem[rp_q];
    else if (ptr_q == IX_IF)   rdata = stat_q;
    else                       rdata = ext_rd_data;
  end

  function automatic logic [FAW-1:0] step(input logic [FAW-1:0] p);
    return (p == FAW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    stat_d = stat_q;
    if (pop && cnt_q == CW'(1) && !push_ok) stat_d[7] = 1'b1;
    if (push_ok)                            stat_d[7] = 1'b0;
    if (do_rd && ptr_q == IX_RST)           stat_d[5] = 1'b1;
    if (do_wr) begin
      if (at_cmd && ctrl_q[0])              stat_d[2] = 1'b0;
      if (ptr_q == IX_IF) begin
        if (!wdata[0])                      stat_d[2] = 1'b1;
        if (!wdata[1]) begin
          stat_d[3] = 1'b1;
          stat_d[6] = 1'b1;
        end
      end
      if (ptr_q == IX_TRIG && ctrl_q[1])    stat_d[3] = 1'b0;
      if (ptr_q == IX_ACK)                  stat_d[6] = 1'b1;
      if (wr_rst)                           stat_d    = 8'hFF;
    end
    if (xfer_done) begin
      stat_d[6] = 1'b0;
      stat_d[3] = 1'b1;
    end
    if (dec_done)                           stat_d[5] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ctrl_q <= '0;
      stat_q <= 8'hFF;
      rp_q   <= '0;
      wp_q   <= '0;
      cnt_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ptr_we)
        ptr_q <= ptr_wdata[PW-1:0];
      else if (do_rd || (do_wr && !at_cmd))
        ptr_q <= ptr_q + 1'b1;
      if (do_wr && ptr_q == IX_IF)
        ctrl_q <= wdata;
      if (wr_rst) begin
        rp_q  <= '0;
        wp_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (pop)     rp_q <= step(rp_q);
        if (push_ok) wp_q <= step(wp_q);
        cnt_q <= cnt_q + CW'(push_ok) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk)
    if (push_ok) mem[wp_q] <= cmd_byte;
endmodule

module host_reg_port_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_we,
  input logic [7:0]    ptr_wdata,
  input logic          data_we,
  input logic          data_re,
  input logic [7:0]    rdata,
  input logic [PW-1:0] reg_idx,
  input logic          xfer_done,
  input logic          dec_done,
  input logic [7:0]    stat,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> reg_idx == $past(ptr_wdata[PW-1:0])); // R1
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !data_we && !ptr_we) |=> reg_idx == PW'($past(reg_idx) + 1'b1)); // R2
  AST_SBOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ptr_we && reg_idx == '0) |=> $stable(reg_idx)); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == '0 && cnt == '0) |-> rdata == 8'hFF); // R4
  AST_RESET_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ptr_we && reg_idx == PW'(15) && !xfer_done && !dec_done)
      |=> (stat == 8'hFF && cnt == '0)); // R7
  AST_HIGH_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx >= PW'(16)) |-> rdata == 8'hFF); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R12
endmodule

bind host_reg_port host_reg_port_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
  .data_we(data_we), .data_re(data_re), .rdata(rdata), .reg_idx(reg_idx),
  .xfer_done(xfer_done), .dec_done(dec_done), .stat(stat_q), .cnt(cnt_q)
);

// File: tb/test_host_reg_port.sv
module test_host_reg_port;
  logic clk = 0, rst_n = 0;
  logic ptr_we = 0, data_we = 0, data_re = 0;
  logic [7:0] ptr_wdata = 0, wdata = 0, ext_rd_data = 0, cmd_byte = 0;
  logic cmd_push = 0, xfer_done = 0, dec_done = 0;
  logic [7:0] rdata;
  logic [4:0] reg_idx;
  logic ext_wr_en, irq;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  host_reg_port i_host_reg_port (
    .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .data_we(data_we), .data_re(data_re), .wdata(wdata), .rdata(rdata),
    .reg_idx(reg_idx), .ext_wr_en(ext_wr_en), .ext_rd_data(ext_rd_data),
    .cmd_push(cmd_push), .cmd_byte(cmd_byte), .xfer_done(xfer_done),
    .dec_done(dec_done), .irq(irq));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (data_re && !ptr_we && !data_we) begin
      if (exp_q.size() == 0) check("scoreboard underrun", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end

  task automatic set_ptr(input logic [7:0] v);
    @(posedge clk); #2 ptr_we = 1; ptr_wdata = v;
    @(posedge clk); #2 ptr_we = 0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #2 data_re = 1;
    @(posedge clk); #2 data_re = 0;
  endtask

  task automatic rd_at(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    set_ptr(idx); rd(exp, tag);
  endtask

  task automatic wr_at(input logic [7:0] idx, input logic [7:0] v, input logic fwd, input string tag);
    set_ptr(idx);
    @(posedge clk); #2 data_we = 1; wdata = v;
    @(negedge clk) check({tag, " ext_wr_en"}, ext_wr_en, fwd);
    @(posedge clk); #2 data_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(posedge clk); #2 cmd_push = 1; cmd_byte = b;
    @(posedge clk); #2 cmd_push = 0;
  endtask

  task automatic pulse(input bit xfer);
    @(posedge clk); #2 if (xfer) xfer_done = 1; else dec_done = 1;
    @(posedge clk); #2 xfer_done = 0; dec_done = 0;
  endtask

  task automatic at_neg(string tag, int act_sel, int exp);
    @(negedge clk);
    check(tag, act_sel == 0 ? int'(reg_idx) : int'(irq), exp);
  endtask

  initial begin
    #1500000;
    check("watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    at_neg("R7 reset index", 0, 0);
    at_neg("R7 reset irq", 1, 0);
    rd(8'hFF, "R4 empty queue after reset");
    set_ptr(8'hE1);
    at_neg("R1 upper bits dropped", 0, 1);
    rd(8'hFF, "R7 reset status");
    at_neg("R2 step after read", 0, 2);
    rd_at(8'h1F, 8'hFF, "R11 index 31 reads FF");
    at_neg("R2 wrap 31 to 0", 0, 0);
    ext_rd_data = 8'h5A;
    rd_at(3, 8'h5A, "R11 forwarded read");
    rd_at(16, 8'hFF, "R11 index 16 reads FF");

    push(8'h11); push(8'h22); push(8'h33);
    rd_at(1, 8'h7F, "R5 pending after push");
    rd_at(0, 8'h11, "R4 first byte");
    rd_at(0, 8'h22, "R4 second byte");
    rd_at(1, 8'h7F, "R5 still pending");
    rd_at(0, 8'h33, "R4 third byte");
    rd_at(1, 8'hFF, "R5 idle when drained");
    rd_at(0, 8'hFF, "R4 drained queue");

    wr_at(1, 8'h83, 0, "R13 control write");
    at_neg("R10 no irq when idle", 1, 0);
    push(8'h44);
    at_neg("R10 irq on command", 1, 1);
    rd_at(0, 8'h44, "R4 byte with irq");
    at_neg("R10 irq withdrawn", 1, 0);

    for (int i = 0; i < 10; i++) push(8'(i + 8'hA0));
    for (int i = 0; i < 8; i++) rd_at(0, 8'(i + 8'hA0), "R12 kept bytes");
    rd_at(0, 8'hFF, "R12 overflow dropped");

    wr_at(0, 8'h77, 1, "R13 serial-out write");
    at_neg("R3 index held on write 0", 0, 0);
    rd_at(1, 8'hFB, "R8 serial write clears busy");
    wr_at(1, 8'h82, 0, "R8 control write");
    rd_at(1, 8'hFF, "R8 serial disable sets busy");

    wr_at(1, 8'h83, 0, "R8 control write");
    wr_at(6, 8'h00, 1, "R13 trigger write");
    rd_at(1, 8'hF7, "R9 trigger clears data busy");
    pulse(1);
    rd_at(1, 8'hBF, "R9 transfer end event");
    at_neg("R10 masked transfer end", 1, 0);
    wr_at(1, 8'hC3, 0, "R10 control write");
    at_neg("R10 transfer end irq", 1, 1);
    wr_at(7, 8'h00, 1, "R13 ack write");
    rd_at(1, 8'hFF, "R9 ack clears transfer end");
    at_neg("R10 irq after ack", 1, 0);

    wr_at(6, 8'h00, 1, "R9 trigger write");
    wr_at(1, 8'h81, 0, "R8 control write");
    rd_at(1, 8'hFF, "R8 output disable sets busy");

    pulse(0);
    rd_at(1, 8'hDF, "R9 decode event");
    wr_at(1, 8'h23, 0, "R10 control write");
    at_neg("R10 decode irq", 1, 1);
    ext_rd_data = 8'h3C;
    rd_at(15, 8'h3C, "R6 read index 15");
    rd_at(1, 8'hFF, "R6 decode flag withdrawn");
    at_neg("R6 irq off", 1, 0);

    push(8'hAA); push(8'hBB); pulse(0);
    rd_at(1, 8'h5F, "R7 before reset write");
    wr_at(15, 8'h00, 0, "R13 reset write");
    at_neg("R2 step after write", 0, 16);
    rd_at(1, 8'hFF, "R7 status after reset write");
    rd_at(0, 8'hFF, "R7 queue emptied");

    push(8'h99);
    set_ptr(0);
    @(posedge clk); #2 ptr_we = 1; ptr_wdata = 8'h00; data_re = 1;
    @(posedge clk); #2 ptr_we = 0; data_re = 0;
    at_neg("R14 index strobe wins", 0, 0);
    rd(8'h99, "R14 no pop on collided read");
    rd_at(0, 8'hFF, "R14 queue drained after read");

    repeat (3) @(posedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule